// File: doc/BRIEF.md
# Paired exclusive load unit

This block runs one paired load-acquire-exclusive instruction word at a time. An instruction comes in on a valid/ready handshake. The block checks the encoding and reads the base address. The base comes from a register-file read port, or from the stack pointer when the base field is 31. The block then fetches the data on a simple request/response memory port and returns two destination register values on two write ports. A word-pair form (two 32-bit elements) uses one atomic 8-byte read, split between the registers by endianness. A doubleword-pair form (two 64-bit elements) needs a 16-byte aligned base and issues two 8-byte reads, one after the other. Nothing is written until both beats have returned cleanly.

The block sends an exclusive-monitor set request covering the whole transfer. A same-register destination pair is handled by a three-way policy input. Undefined-instruction, alignment and memory faults are reported on their own outputs. A one-cycle completion pulse marks retirement or a fault. Words that do not match the encoding are flagged and otherwise ignored. Memory response data is taken as the 64-bit value already in access byte order.

Top module: `pair_excl_load`

## Requirements
- R1: An instruction word matches only when all of these hold: bit 31 = 1, bits 29:23 = 7'b0010000, bits 22, 21 and 15 = 1, and bits 20:16 = 5'b11111. The element size is bit 30 (0 gives 32-bit elements, 1 gives 64-bit elements). Rt is in bits 4:0, the base field is in bits 9:5 and Rt2 is in bits 14:10. A non-matching word gives `not_mine` for one cycle, the cycle after acceptance. It causes no write, no `done`, no exclusive request and no memory read.
- R2: 32-bit form with `big_endian`=0: exactly one 8-byte read at the base. Port 0 writes Rt with the low word and port 1 writes Rt2 with the high word, each zero-extended to 64 bits.
- R3: 32-bit form with `big_endian`=1: port 0 writes Rt with the high word and port 1 writes Rt2 with the low word, each zero-extended.
- R4: 64-bit form: two reads, first at the base and then at base+8. Rt gets the first result and Rt2 the second. Both ports write in the same cycle, after the second response.
- R5: When the base field is 31, the base is `sp_val`. If `sp_val` is not a multiple of SP_ALIGN, `align_fault` and `done` are raised with no write, no exclusive request and no read.
- R6: Outside the overlap case, the base must be a multiple of 16 (64-bit form) or 8 (32-bit form). Otherwise `align_fault` and `done` are raised with no write, no exclusive request and no read.
- R7: When Rt equals Rt2 and `overlap_mode`=0, port 0 alone writes FILL to Rt. An exclusive request is made and no read is done. Only the stack-pointer check of R5 applies, not the size alignment of R6.
- R8: When Rt equals Rt2 and `overlap_mode` is 1 or 3, `undef_fault` and `done` are raised with no other effect. This takes priority over R5.
- R9: When Rt equals Rt2 and `overlap_mode`=2, only `done` is raised. This takes priority over R5.
- R10: Every instruction that reaches memory or the R7 path pulses `excl_set` in the cycle after acceptance. `excl_addr` is the base and `excl_len` is 8 (32-bit form) or 16 (64-bit form).
- R11: An error response on any beat raises `mem_fault` with `done` and suppresses both writes. An error on the first 64-bit beat means the second read is never issued.
- R12: `done` is high for exactly one cycle per matching instruction, together with its writes or fault. Writes and faults never appear without `done`. `in_ready` is low while a memory access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_insn | input | 32 | Instruction word |
| big_endian | input | 1 | Data access byte order is big-endian |
| overlap_mode | input | 2 | Same-destination policy: 0 fill, 1/3 undefined, 2 no-op |
| rf_raddr | output | 5 | Register-file read index (base field) |
| rf_rdata | input | 64 | Register-file read data |
| sp_val | input | 64 | Stack pointer value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_addr | output | 64 | Read address (8-byte access) |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 64 | Read response data |
| mem_rsp_err | input | 1 | Read response carries an error |
| wr0_en | output | 1 | Write port 0 enable |
| wr0_idx | output | 5 | Write port 0 register index |
| wr0_data | output | 64 | Write port 0 data |
| wr1_en | output | 1 | Write port 1 enable |
| wr1_idx | output | 5 | Write port 1 register index |
| wr1_data | output | 64 | Write port 1 data |
| excl_set | output | 1 | Exclusive monitor set pulse |
| excl_addr | output | 64 | Start of exclusive range |
| excl_len | output | 5 | Exclusive range length in bytes |
| not_mine | output | 1 | Word did not match the encoding |
| undef_fault | output | 1 | Undefined instruction raised |
| align_fault | output | 1 | Alignment fault raised |
| mem_fault | output | 1 | Memory error response seen |
| done | output | 1 | Instruction retired or faulted |

## Verification
The bench builds the block with SP_ALIGN=16 and a FILL pattern that no memory location in the bench returns. A fill write therefore cannot be mistaken for read data. With a 16-byte stack rule, a stack base that is 8-byte aligned but not 16-byte aligned fails in the 32-bit form, even though the same base would pass R6. This is how the stack check is told apart from the size check. The memory model can fail a chosen address, so an error can be placed on either beat of the 64-bit sequence.

// File: rtl/pair_excl_load.sv
module pair_excl_load #(
  parameter int unsigned SP_ALIGN = 16,
  parameter logic [63:0] FILL = 64'hDEAD_BEEF_DEAD_BEEF
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_insn,
  input  logic        big_endian,
  input  logic [1:0]  overlap_mode,
  output logic [4:0]  rf_raddr,
  input  logic [63:0] rf_rdata,
  input  logic [63:0] sp_val,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err,
  output logic        wr0_en,
  output logic [4:0]  wr0_idx,
  output logic [63:0] wr0_data,
  output logic        wr1_en,
  output logic [4:0]  wr1_idx,
  output logic [63:0] wr1_data,
  output logic        excl_set,
  output logic [63:0] excl_addr,
  output logic [4:0]  excl_len,
  output logic        not_mine,
  output logic        undef_fault,
  output logic        align_fault,
  output logic        mem_fault,
  output logic        done
);
  localparam logic [63:0] SP_MASK = 64'(SP_ALIGN - 1);

  typedef enum logic [1:0] {IDLE, REQ, RSP} st_t;
  st_t st;

  logic        sz_q, be_q, beat;
  logic [63:0] base_q, first_q;

  wire [4:0]  f_t   = in_insn[4:0];
  wire [4:0]  f_n   = in_insn[9:5];
  wire [4:0]  f_t2  = in_insn[14:10];
  wire        f_sz  = in_insn[30];
  wire        match = in_insn[31] && in_insn[29:23] == 7'b0010000 && in_insn[22]
                   && in_insn[21] && (&in_insn[20:16]) && in_insn[15];
  wire        use_sp   = &f_n;
  wire [63:0] base     = use_sp ? sp_val : rf_rdata;
  wire        sp_bad   = use_sp && ((sp_val & SP_MASK) != 64'd0);
  wire        overlap  = f_t == f_t2;
  wire        size_bad = f_sz ? (base[3:0] != 4'd0) : (base[2:0] != 3'd0);
  wire        accept   = in_valid && in_ready;

  assign rf_raddr      = f_n;
  assign in_ready      = st == IDLE;
  assign mem_req_valid = st == REQ;
  assign mem_addr      = beat ? base_q + 64'd8 : base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      sz_q <= 1'b0; be_q <= 1'b0; beat <= 1'b0;
      base_q <= '0; first_q <= '0;
      wr0_en <= 1'b0; wr0_idx <= '0; wr0_data <= '0;
      wr1_en <= 1'b0; wr1_idx <= '0; wr1_data <= '0;
      excl_set <= 1'b0; excl_addr <= '0; excl_len <= '0;
      not_mine <= 1'b0; undef_fault <= 1'b0; align_fault <= 1'b0;
      mem_fault <= 1'b0; done <= 1'b0;
    end else begin
      wr0_en <= 1'b0; wr1_en <= 1'b0; excl_set <= 1'b0;
      not_mine <= 1'b0; undef_fault <= 1'b0; align_fault <= 1'b0;
      mem_fault <= 1'b0; done <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          if (!match) begin
            not_mine <= 1'b1;
          end else if (overlap && overlap_mode != 2'd0) begin
            done <= 1'b1;
            undef_fault <= overlap_mode != 2'd2;
          end else if (sp_bad) begin
            align_fault <= 1'b1;
            done <= 1'b1;
          end else if (overlap) begin
            excl_set  <= 1'b1;
            excl_addr <= base;
            excl_len  <= f_sz ? 5'd16 : 5'd8;
            wr0_en    <= 1'b1;
            wr0_idx   <= f_t;
            wr0_data  <= FILL;
            done      <= 1'b1;
          end else if (size_bad) begin
            align_fault <= 1'b1;
            done <= 1'b1;
          end else begin
            excl_set  <= 1'b1;
            excl_addr <= base;
            excl_len  <= f_sz ? 5'd16 : 5'd8;
            base_q    <= base;
            sz_q      <= f_sz;
            be_q      <= big_endian;
            wr0_idx   <= f_t;
            wr1_idx   <= f_t2;
            beat      <= 1'b0;
            st        <= REQ;
          end
        end
        REQ: if (mem_req_ready) st <= RSP;
        RSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            mem_fault <= 1'b1;
            done <= 1'b1;
            st <= IDLE;
          end else if (!sz_q) begin
            wr0_en   <= 1'b1;
            wr1_en   <= 1'b1;
            wr0_data <= {32'd0, be_q ? mem_rsp_data[63:32] : mem_rsp_data[31:0]};
            wr1_data <= {32'd0, be_q ? mem_rsp_data[31:0] : mem_rsp_data[63:32]};
            done <= 1'b1;
            st <= IDLE;
          end else if (!beat) begin
            first_q <= mem_rsp_data;
            beat <= 1'b1;
            st <= REQ;
          end else begin
            wr0_en   <= 1'b1;
            wr1_en   <= 1'b1;
            wr0_data <= first_q;
            wr1_data <= mem_rsp_data;
            done <= 1'b1;
            st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module pair_excl_load_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic mem_req_valid,
  input logic done,
  input logic not_mine,
  input logic wr0_en,
  input logic wr1_en,
  input logic undef_fault,
  input logic align_fault,
  input logic mem_fault,
  input logic excl_set,
  input logic [4:0] excl_len
);
  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !in_ready);
  a_r12_effects_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0_en || undef_fault || align_fault || mem_fault) |-> done);
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> !done && !wr0_en && !wr1_en && !excl_set);
  a_r11_no_write_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault |-> !wr0_en && !wr1_en);
  a_r6_no_write_on_align: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !wr0_en && !wr1_en && !excl_set);
  a_r4_port1_pairs_port0: assert property (@(posedge clk) disable iff (!rst_n)
    wr1_en |-> wr0_en);
  a_r10_excl_len: assert property (@(posedge clk) disable iff (!rst_n)
    excl_set |-> (excl_len == 5'd8 || excl_len == 5'd16));
  a_r12_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({undef_fault, align_fault, mem_fault}) <= 1);
endmodule

bind pair_excl_load pair_excl_load_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_req_valid(mem_req_valid),
  .done(done), .not_mine(not_mine), .wr0_en(wr0_en), .wr1_en(wr1_en),
  .undef_fault(undef_fault), .align_fault(align_fault), .mem_fault(mem_fault),
  .excl_set(excl_set), .excl_len(excl_len)
);

// File: tb/pair_excl_load_tb.sv
module pair_excl_load_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] FILL_V = 64'hF1F1_0000_C0DE_7777;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_insn = '0;
  logic big_endian = 1'b0;
  logic [1:0] overlap_mode = 2'd0;
  logic [4:0] rf_raddr;
  logic [63:0] rf_rdata;
  logic [63:0] sp_val = 64'h3000_0000;
  logic mem_req_valid, mem_req_ready;
  logic [63:0] mem_addr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic wr0_en, wr1_en;
  logic [4:0] wr0_idx, wr1_idx;
  logic [63:0] wr0_data, wr1_data;
  logic excl_set;
  logic [63:0] excl_addr;
  logic [4:0] excl_len;
  logic not_mine, undef_fault, align_fault, mem_fault, done;

  logic [63:0] regs [32];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF0;
  logic [63:0] rd_q [$];
  logic pend = 1'b0;
  logic [63:0] pend_addr = '0;
  int tests = 0, fails = 0;

  assign rf_rdata = regs[rf_raddr];
  assign mem_req_ready = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_excl_load #(.SP_ALIGN(16), .FILL(FILL_V)) dut_i (.*);

  function automatic logic [63:0] md(input logic [63:0] a);
    return {a[31:0] ^ 32'h5A5A_1234, a[31:0] + 32'h0F0F_0000};
  endfunction

  function automatic logic [31:0] enc(input logic sz, input logic [4:0] t2, input logic [4:0] n, input logic [4:0] t);
    return {1'b1, sz, 7'b0010000, 1'b1, 1'b1, 5'h1f, 1'b1, t2, n, t};
  endfunction

  always @(negedge clk) begin
    if (pend) begin
      pend = 1'b0;
      mem_rsp_valid = 1'b1;
      mem_rsp_data = md(pend_addr);
      mem_rsp_err = (pend_addr == err_addr);
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
    end
    if (mem_req_valid) begin
      pend = 1'b1;
      pend_addr = mem_addr;
      rd_q.push_back(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] insn, input string req);
    logic nm = 0, und = 0, al = 0, mf = 0, w0 = 0, w1 = 0, ex = 0;
    logic [63:0] d0 = '0, d1 = '0, b = '0, exl = '0;
    logic [63:0] rexp [$];
    logic [4:0] t = insn[4:0], n = insn[9:5], t2 = insn[14:10];
    logic sz = insn[30];
    bit seen = 0, busy_ok = 1, ex_seen = 0;
    rexp = {};
    if (insn[31:15] != {1'b1, sz, 7'b0010000, 1'b1, 1'b1, 5'h1f, 1'b1}) nm = 1;
    else begin
      b = (n == 5'd31) ? sp_val : regs[n];
      exl = sz ? 64'd16 : 64'd8;
      if (t == t2 && overlap_mode != 2'd0) und = (overlap_mode != 2'd2);
      else if (n == 5'd31 && (sp_val % 16) != 0) al = 1;
      else if (t == t2) begin ex = 1; w0 = 1; d0 = FILL_V; end
      else if ((b % exl) != 0) al = 1;
      else begin
        ex = 1;
        rexp.push_back(b);
        if (b == err_addr) mf = 1;
        else if (sz) begin
          rexp.push_back(b + 64'd8);
          if (b + 64'd8 == err_addr) mf = 1;
          else begin w0 = 1; w1 = 1; d0 = md(b); d1 = md(b + 64'd8); end
        end else begin
          w0 = 1; w1 = 1;
          d0 = big_endian ? {32'd0, md(b)[63:32]} : {32'd0, md(b)[31:0]};
          d1 = big_endian ? {32'd0, md(b)[31:0]} : {32'd0, md(b)[63:32]};
        end
      end
    end
    rd_q = {};
    @(negedge clk);
    in_insn = insn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (mem_req_valid && in_ready) busy_ok = 0;
      if (excl_set) begin
        ex_seen = 1;
        chk(ex && i == 0, "R10", "excl pulse timing", 64'(i), 64'd0);
        chk(excl_addr == b, "R10", "excl addr", excl_addr, b);
        chk(64'(excl_len) == exl, "R10", "excl len", 64'(excl_len), exl);
      end
      if (done || not_mine) begin
        seen = 1;
        chk(not_mine == nm && done == !nm, req, "not_mine/done", {not_mine, done}, {nm, !nm});
        chk(undef_fault == und && align_fault == al && mem_fault == mf, req, "faults",
            {undef_fault, align_fault, mem_fault}, {und, al, mf});
        chk(wr0_en == w0 && wr1_en == w1, req, "write enables", {wr0_en, wr1_en}, {w0, w1});
        if (w0) chk(wr0_idx == t && wr0_data == d0, req, "port0", wr0_data, d0);
        if (w1) chk(wr1_idx == t2 && wr1_data == d1, req, "port1", wr1_data, d1);
        break;
      end
      if (wr0_en || wr1_en) chk(0, "R12", "write without done", 1, 0);
      @(negedge clk);
    end
    chk(seen, req, "completion seen", 64'(seen), 1);
    chk(ex_seen == ex, "R10", "excl request presence", 64'(ex_seen), 64'(ex));
    chk(busy_ok, "R12", "ready low while reading", 64'(busy_ok), 1);
    @(negedge clk);
    chk(!done && !not_mine, "R12", "pulse lasts one cycle", {done, not_mine}, 0);
    chk(rd_q.size() == rexp.size(), req, "read count", 64'(rd_q.size()), 64'(rexp.size()));
    if (rd_q.size() == rexp.size())
      foreach (rexp[k]) chk(rd_q[k] == rexp[k], req, "read address", rd_q[k], rexp[k]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 64'h1000_0000 + 64'(i) * 64'h100;
    regs[4] = 64'h2000_0108;
    regs[5] = 64'h2000_0104;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !done && !not_mine && !mem_req_valid && !wr0_en, "R12", "reset state",
        {in_ready, done, not_mine, mem_req_valid}, 64'b1000);

    run(enc(0, 2, 3, 1) & ~32'h0000_8000, "R1");
    run(enc(0, 2, 3, 1) & ~32'h0001_0000, "R1");
    run(enc(0, 2, 3, 1) & ~32'h0040_0000, "R1");
    big_endian = 0; run(enc(0, 2, 3, 1), "R2");
    big_endian = 1; run(enc(0, 7, 6, 8), "R3");
    big_endian = 0; run(enc(1, 10, 3, 9), "R4");
    big_endian = 1; run(enc(1, 0, 6, 30), "R4");
    big_endian = 0;
    run(enc(1, 2, 4, 1), "R6");
    run(enc(0, 2, 5, 1), "R6");
    run(enc(0, 2, 4, 1), "R6");
    sp_val = 64'h3000_0020; run(enc(0, 2, 31, 1), "R5");
    sp_val = 64'h3000_0028; run(enc(0, 2, 31, 1), "R5");
    sp_val = 64'h3000_0030; run(enc(1, 12, 31, 11), "R5");
    overlap_mode = 0; run(enc(0, 9, 3, 9), "R7");
    run(enc(1, 9, 4, 9), "R7");
    sp_val = 64'h3000_0008; run(enc(1, 9, 31, 9), "R7");
    overlap_mode = 1; run(enc(0, 9, 3, 9), "R8");
    overlap_mode = 3; run(enc(1, 9, 31, 9), "R8");
    overlap_mode = 2; run(enc(0, 9, 31, 9), "R9");
    overlap_mode = 0; sp_val = 64'h3000_0000;
    err_addr = 64'h1000_0300; run(enc(1, 2, 3, 1), "R11");
    err_addr = 64'h1000_0308; run(enc(1, 2, 3, 1), "R11");
    err_addr = 64'h1000_0600; run(enc(0, 2, 6, 1), "R11");
    err_addr = 64'hFFFF_FFFF_FFFF_FFF0;
    run(enc(0, 2, 3, 1), "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule